// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block takes a floating-point value that has already been unpacked into a class tag, a sign, an unbiased exponent and a normalised mantissa with a sticky bit. It produces a two's-complement signed integer. One input bit selects the result width: 32-bit or 64-bit. The conversion always truncates toward zero, so no rounding mode enters it.

Alongside the integer, the block reports two flags. The inexact flag says that nonzero fraction bits were discarded. The invalid flag says that the value could not be represented and the result was saturated. Results are registered, so each conversion appears one clock after its operands are presented. A new conversion may start every cycle.

The mantissa is `MANT_W` bits wide. Its top bit is the integer bit of 1.f, so the value is mant × 2^(exp − (MANT_W−1)). For example, with the default `MANT_W` of 66 and an exponent of 31, mantissa bit 34 is the integer bit of weight 1.

Top module: `fp_to_int_trunc`

## Requirements
- R1: The class code 2'b00 (zero) yields a result of 0 with both flags low, whatever the other inputs are.
- R2: For class 2'b01 (number) with an in-range value, the result magnitude is the integer part of mant × 2^(exp−(MANT_W−1)). This is truncation toward zero.
- R3: A negative in-range number (sign_i = 1) yields the two's-complement negation of its truncated magnitude. A positive number never yields a negative result.
- R4: inexact_o is high exactly when an in-range number loses nonzero bits in the alignment, or when sticky_i is set. An exponent below zero gives 0, with inexact_o set.
- R5: A number overflows in either of two cases, and then saturates with invalid_o high:
  - its exponent is at least 32 (narrow width) or at least 64 (wide width);
  - its truncated magnitude is at least 2^31 + sign (narrow) or 2^63 + sign (wide).
  Hence −2^31 and −2^63 are legal results.
- R6: Class 2'b10 (infinity) and class 2'b11 (NaN) saturate with invalid_o high.
- R7: Saturation yields the largest positive value for a positive sign and the most negative value for a negative sign. It raises invalid_o and clears inexact_o, so the two flags are never high together.
- R8: With wide_i = 0, res_o[63:32] is the sign extension of res_o[31:0]. With wide_i = 1, all 64 bits form the result.
- R9: Outputs update one clock after their inputs. While rst_n is low they are held at 0 with both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cls_i | input | 2 | Class: 00 zero, 01 number, 10 infinity, 11 NaN |
| sign_i | input | 1 | 1 = negative |
| exp_i | input | EXP_W | Unbiased signed exponent |
| mant_i | input | MANT_W | Mantissa, top bit is the integer bit |
| sticky_i | input | 1 | Nonzero bits below the mantissa |
| wide_i | input | 1 | 1 = 64-bit result, 0 = 32-bit result |
| res_o | output | 64 | Integer result |
| inexact_o | output | 1 | Fraction bits were discarded |
| invalid_o | output | 1 | Result saturated |

## Verification
The hardest cases to reach are those that sit exactly on the range edge: a magnitude of exactly 2^31 or 2^63, with either sign, with and without fraction bits below it. At that edge, a value that is legal for a negative sign saturates for a positive one, and the inexact flag must be dropped when saturation wins. Random mantissas with a random exponent almost never land there, so directed operands construct those edges at both widths. The random stimulus draws exponents around 31, 32, 63 and 64, and clears random runs of low mantissa bits so that exact and inexact outcomes both occur often.

// File: rtl/fp_to_int_trunc.sv
module fp_to_int_trunc #(
  parameter int MANT_W = 66,
  parameter int EXP_W  = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              cls_i,
  input  logic                    sign_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [MANT_W-1:0]       mant_i,
  input  logic                    sticky_i,
  input  logic                    wide_i,
  output logic [63:0]             res_o,
  output logic                    inexact_o,
  output logic                    invalid_o
);

  localparam logic [1:0] CLS_ZERO = 2'd0;
  localparam logic [1:0] CLS_NUM  = 2'd1;
  localparam logic [1:0] CLS_INF  = 2'd2;
  localparam logic [1:0] CLS_NAN  = 2'd3;
  localparam int TOP = MANT_W - 1;
  localparam logic signed [EXP_W-1:0] E_NARROW = EXP_W'(32);
  localparam logic signed [EXP_W-1:0] E_WIDE   = EXP_W'(64);
  localparam logic signed [EXP_W-1:0] E_ZERO   = '0;

  logic              exp_neg, exp_big;
  logic [31:0]       shamt;
  logic [MANT_W-1:0] aligned;
  logic              lost;
  logic [64:0]       mag, limit;
  logic              range_ovf, saturate;
  logic [63:0]       signed_val, sat_val, next_res;
  logic              next_inx;

  assign exp_neg = exp_i < E_ZERO;
  assign exp_big = wide_i ? (exp_i >= E_WIDE) : (exp_i >= E_NARROW);
  assign shamt   = (exp_neg || exp_big) ? 32'd0 : (32'(TOP) - 32'(exp_i));

  always_comb begin
    if (exp_neg) begin
      aligned = '0;
      lost    = |mant_i;
    end else begin
      aligned = mant_i >> shamt;
      lost    = (aligned << shamt) != mant_i;
    end
  end

  assign mag       = 65'(aligned);
  assign limit     = (wide_i ? (65'd1 << 63) : (65'd1 << 31)) + 65'(sign_i);
  assign range_ovf = exp_big || (mag >= limit);

  assign signed_val = sign_i ? (~mag[63:0] + 64'd1) : mag[63:0];
  assign sat_val    = wide_i ? {sign_i, {63{~sign_i}}}
                             : {{33{sign_i}}, {31{~sign_i}}};

  assign saturate = (cls_i == CLS_INF) || (cls_i == CLS_NAN) ||
                    ((cls_i == CLS_NUM) && range_ovf);

  always_comb begin
    next_res = '0;
    next_inx = 1'b0;
    if (saturate) begin
      next_res = sat_val;
    end else if (cls_i == CLS_NUM) begin
      next_res = wide_i ? signed_val : {{32{signed_val[31]}}, signed_val[31:0]};
      next_inx = lost || sticky_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_o     <= '0;
      inexact_o <= 1'b0;
      invalid_o <= 1'b0;
    end else begin
      res_o     <= next_res;
      inexact_o <= next_inx;
      invalid_o <= saturate;
    end
  end

  a_r1_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == CLS_ZERO) |=> (res_o == 64'd0 && !inexact_o && !invalid_o));

  a_r6_special_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == CLS_INF || cls_i == CLS_NAN) |=> (invalid_o && !inexact_o));

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(inexact_o && invalid_o));

  a_r8_narrow_sext: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_i |=> (res_o[63:32] == {32{res_o[31]}}));

  a_r5_big_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == CLS_NUM && !wide_i && exp_i >= E_NARROW) |=> invalid_o);

  a_r3_positive_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == CLS_NUM && !sign_i) |=> !res_o[63]);

endmodule

// File: tb/fp_to_int_trunc_bench.sv
`timescale 1ns/1ps
module fp_to_int_trunc_bench;
  localparam int MW = 66;
  localparam int EW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cls = 2'd0;
  logic sgn = 1'b0;
  logic signed [EW-1:0] ex = '0;
  logic [MW-1:0] mant = '0;
  logic sticky = 1'b0;
  logic wide = 1'b0;
  logic [63:0] res;
  logic inx, inv;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fp_to_int_trunc #(.MANT_W(MW), .EXP_W(EW)) u_fp_to_int_trunc (
    .clk(clk), .rst_n(rst_n), .cls_i(cls), .sign_i(sgn), .exp_i(ex),
    .mant_i(mant), .sticky_i(sticky), .wide_i(wide),
    .res_o(res), .inexact_o(inx), .invalid_o(inv));

  function automatic logic [65:0] model(input logic [1:0] c, input logic s, input int e,
                                        input logic [MW-1:0] m, input logic st, input logic w);
    logic [127:0] ip;
    logic [127:0] lim;
    logic fr;
    logic [63:0] r;
    int n;
    n = w ? 64 : 32;
    if (c == 2'd0) return 66'd0;
    if (c == 2'd1 && e < n) begin
      ip = '0;
      fr = st;
      for (int k = 0; k < MW; k++) begin
        if (m[k]) begin
          if (e - (MW - 1) + k >= 0) ip[e - (MW - 1) + k] = 1'b1;
          else fr = 1'b1;
        end
      end
      lim = (128'd1 << (n - 1)) + 128'(s);
      if (ip < lim) begin
        r = s ? (~ip[63:0] + 64'd1) : ip[63:0];
        if (!w) r = {{32{r[31]}}, r[31:0]};
        return {r, fr, 1'b0};
      end
    end
    r = (64'd1 << (n - 1)) - 64'd1;
    if (s) r = ~r;
    return {r, 1'b0, 1'b1};
  endfunction

  task automatic run(input logic [1:0] c, input logic s, input int e, input logic [MW-1:0] m,
                     input logic st, input logic w, input logic [63:0] er,
                     input logic ei, input logic ev, input string tag);
    @(negedge clk);
    cls = c; sgn = s; ex = EW'(e); mant = m; sticky = st; wide = w;
    @(negedge clk);
    checks++;
    if (res !== er || inx !== ei || inv !== ev) begin
      errors++;
      $display("FAIL %s: got res=%h inx=%b inv=%b expected res=%h inx=%b inv=%b",
               tag, res, inx, inv, er, ei, ev);
    end
  endtask

  localparam logic [MW-1:0] ONE = {1'b1, {(MW-1){1'b0}}};

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [65:0] exv;
    logic [MW-1:0] m;
    logic [1:0] c;
    int e;
    int k;
    logic s, st, w;
    void'($urandom(32'd20240611));
    cls = 2'd1; sgn = 1'b1; ex = EW'(5); mant = ONE; sticky = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (res !== 64'd0 || inx !== 1'b0 || inv !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: got res=%h inx=%b inv=%b expected 0 0 0", res, inx, inv);
    end
    rst_n = 1'b1;

    run(2'd0, 1'b1, 40, '1, 1'b1, 1'b0, 64'd0, 1'b0, 1'b0, "R1 zero class");
    run(2'd1, 1'b0, 2, ONE | (ONE >> 2), 1'b0, 1'b0, 64'd5, 1'b0, 1'b0, "R2 exact five");
    run(2'd1, 1'b0, 1, ONE | (ONE >> 1) | (ONE >> 2) | (ONE >> 3), 1'b0, 1'b0,
        64'd3, 1'b1, 1'b0, "R2 R4 3.75 truncated");
    run(2'd1, 1'b1, 1, ONE | (ONE >> 1) | (ONE >> 2) | (ONE >> 3), 1'b0, 1'b0,
        64'hFFFF_FFFF_FFFF_FFFD, 1'b1, 1'b0, "R3 -3.75 truncated");
    run(2'd1, 1'b1, -1, ONE, 1'b0, 1'b1, 64'd0, 1'b1, 1'b0, "R4 -0.5 to zero");
    run(2'd1, 1'b0, 5, ONE, 1'b1, 1'b0, 64'd32, 1'b1, 1'b0, "R4 sticky only");
    run(2'd1, 1'b1, 31, ONE, 1'b0, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0, "R5 -2^31 legal");
    run(2'd1, 1'b0, 31, ONE, 1'b0, 1'b0, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b1, "R5 +2^31 saturates");
    run(2'd1, 1'b1, 31, ONE | 1, 1'b0, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0, "R5 -2^31 with fraction");
    run(2'd1, 1'b1, 31, ONE | (ONE >> 31), 1'b1, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b1,
        "R7 -(2^31+1) saturates, inexact cleared");
    run(2'd1, 1'b0, 32, ONE, 1'b0, 1'b0, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b1, "R5 exponent 32 narrow");
    run(2'd1, 1'b1, 63, ONE, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b0, "R5 -2^63 legal");
    run(2'd1, 1'b0, 63, ONE, 1'b0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, "R5 +2^63 saturates");
    run(2'd1, 1'b1, 40, ONE, 1'b0, 1'b1, 64'hFFFF_FF00_0000_0000, 1'b0, 1'b0, "R8 wide -2^40");
    run(2'd1, 1'b1, 40, ONE, 1'b0, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b1, "R8 narrow -2^40 saturates");
    run(2'd2, 1'b0, 0, ONE, 1'b1, 1'b0, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b1, "R6 +inf narrow");
    run(2'd2, 1'b1, 0, ONE, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b1, "R6 -inf wide");
    run(2'd3, 1'b1, 0, ONE, 1'b0, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b1, "R6 NaN negative");

    for (int i = 0; i < 3000; i++) begin
      k = int'($urandom_range(0, 9));
      c = (k == 0) ? 2'd0 : (k == 1) ? 2'd2 : (k == 2) ? 2'd3 : 2'd1;
      s = 1'($urandom);
      w = 1'($urandom);
      st = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 1) == 0) begin
        k = int'($urandom_range(0, 7));
        e = (k < 2) ? 30 + k : (k < 4) ? 32 + k - 2 : (k < 6) ? 62 + k - 4 : 64 + k - 6;
      end else begin
        e = int'($urandom_range(0, 74)) - 6;
      end
      m = MW'({$urandom, $urandom, $urandom}) | ONE;
      k = int'($urandom_range(0, MW - 1));
      m = m & ({MW{1'b1}} << k);
      exv = model(c, s, e, m, st, w);
      run(c, s, e, m, st, w, exv[65:2], exv[1], exv[0], "R2 R3 R4 R5 R7 R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule